// File: doc/BRIEF.md
# Cascaded Three-Stage Sigma-Delta Division Modulator

This block produces the modulus for a fractional-N divider. On every enabled reference clock it adds an unsigned fractional word to a chain of up to three accumulators. It combines their overflow carries into a small signed offset and adds that offset to an integer part. The modulus that results averages to the integer part plus the word divided by 2^ACC_W. The quantization error of the average is pushed to high frequencies by (1 - z^-1)^m, where m is the order.

The order is picked at run time: one, two or three stages. A synchronous reset loads a separate seed into every accumulator. A non-zero seed breaks up the short periodic patterns that appear when the fractional word is a simple ratio. A clock enable freezes every register in the block.

Top module: `mash111_mod`

## Requirements
- R1: Each active stage adds its input to its state on every enabled edge. When the sum exceeds 2^ACC_W - 1, the stage carry is 1 and the new state is the sum minus 2^ACC_W. Otherwise the carry is 0 and the new state is the sum.
- R2: Stage 1 adds `k_i`. Stage 2 adds the updated state of stage 1 from the same edge, and stage 3 adds the updated state of stage 2 from the same edge.
- R3: The offset is c1 + (c2 - c2') + (c3 - 2*c3' + c3''), where a prime marks the value from the previous enabled edge and a double prime the value from the edge before that. The offset is a signed 4-bit value. It stays within 0..1 for order 1, within -1..2 for order 2 and within -3..4 for order 3.
- R4: `ord_i` values 0 and 1 select order 1, 2 selects order 2 and 3 selects order 3. The state, carries and delayed carries of every stage above the selected order are held at zero and add nothing to the offset.
- R5: `mod_o` is the registered value of `int_i` plus the sign-extended offset, taken modulo 2^(INT_W+1). It changes on the same edge at which the accumulators update.
- R6: While `rst_i` is high at a clock edge, stage k is loaded with bits [k*ACC_W +: ACC_W] of `seed_i` (k = 0, 1, 2). The same edge clears the delayed carries and `mod_o`. Reset takes priority over `en_i`.
- R7: While `en_i` is low, every accumulator, every delayed carry and `mod_o` keep their values.
- R8: Over n enabled cycles with a constant `k_i`, the sum of the offsets is within 4 of n*k_i/2^ACC_W.
- R9: With order 1, seeds of zero and `k_i` = 2^(ACC_W-2), the offset repeats the pattern 0, 0, 0, 1. A stage-1 seed of 3*2^(ACC_W-2) moves the first carry to the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous reset, active high; loads the seeds |
| en_i | input | 1 | Clock enable; when low, all state is held |
| k_i | input | ACC_W | Unsigned fractional word |
| int_i | input | INT_W | Integer part of the division ratio |
| ord_i | input | 2 | Order select (0/1: first, 2: second, 3: third) |
| seed_i | input | 3*ACC_W | Reset values of the accumulators, stage k at bits [k*ACC_W +: ACC_W] |
| mod_o | output | INT_W+1 | Registered divider modulus |

## Verification
The assertions check on every cycle that the offset stays inside the range of the selected order. They also check that stages above the selected order stay at zero, and that state and output do not move while the enable is low. The bench scenarios show what a per-cycle property cannot. A behavioural model, stepped in lock-step with the design, shows the exact carry arithmetic and the way the stages chain together. Directed scenarios show the period-four pattern for a quarter input, the shift caused by a seed, modulus wrap-around, order changes during a run, and convergence of the long-run mean to the fractional word.

// File: rtl/mash111_pkg.sv
`timescale 1ns/1ps
package mash111_pkg;
    localparam int NSTG  = 3;
    localparam int OFF_W = 4;
    typedef logic signed [OFF_W-1:0] off_t;

    // Active-stage mask for an order select value
    function automatic logic [NSTG-1:0] ord_mask(input logic [1:0] ord);
        case (ord)
            2'd2:    ord_mask = 3'b011;
            2'd3:    ord_mask = 3'b111;
            default: ord_mask = 3'b001;
        endcase
    endfunction
endpackage

// File: rtl/mash111_stage.sv
`timescale 1ns/1ps
module mash111_stage #(
    parameter int ACC_W = 19
) (
    input  logic             act_i,
    input  logic [ACC_W-1:0] add_i,
    input  logic [ACC_W-1:0] state_i,
    output logic [ACC_W-1:0] nxt_o,
    output logic             carry_o
);
    logic [ACC_W:0] sum;

    always_comb begin
        sum = {1'b0, state_i} + {1'b0, add_i};
        if (act_i) begin
            nxt_o   = sum[ACC_W-1:0];
            carry_o = sum[ACC_W];
        end else begin
            nxt_o   = '0;
            carry_o = 1'b0;
        end
    end
endmodule

// File: rtl/mash111_comb.sv
`timescale 1ns/1ps
module mash111_comb
    import mash111_pkg::*;
(
    input  logic [NSTG-1:0] act_i,
    input  logic [NSTG-1:0] cy_i,
    input  logic            c2_z1_i,
    input  logic            c3_z1_i,
    input  logic            c3_z2_i,
    output off_t            off_o
);
    localparam logic [OFF_W-2:0] ZP = '0;

    off_t acc;

    always_comb begin
        acc = off_t'({ZP, cy_i[0]});
        if (act_i[1]) begin
            acc = acc + off_t'({ZP, cy_i[1]}) - off_t'({ZP, c2_z1_i});
        end
        if (act_i[2]) begin
            acc = acc + off_t'({ZP, cy_i[2]})
                      - off_t'({ZP[OFF_W-3:0], c3_z1_i, 1'b0})
                      + off_t'({ZP, c3_z2_i});
        end
        off_o = acc;
    end
endmodule

// File: rtl/mash111_mod.sv
`timescale 1ns/1ps
module mash111_mod
    import mash111_pkg::*;
#(
    parameter int ACC_W = 19,
    parameter int INT_W = 8,
    localparam int MOD_W = INT_W + 1
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  en_i,
    input  logic [ACC_W-1:0]      k_i,
    input  logic [INT_W-1:0]      int_i,
    input  logic [1:0]            ord_i,
    input  logic [NSTG*ACC_W-1:0] seed_i,
    output logic [MOD_W-1:0]      mod_o
);
    typedef struct packed {
        logic [NSTG-1:0][ACC_W-1:0] acc;
        logic                       c2_z1;
        logic                       c3_z1;
        logic                       c3_z2;
        logic [MOD_W-1:0]           modv;
    } state_t;

    state_t st_d, st_q;

    logic [NSTG-1:0]            act;
    logic [NSTG-1:0][ACC_W-1:0] add_w;
    logic [NSTG-1:0][ACC_W-1:0] nxt_w;
    logic [NSTG-1:0]            cy_w;
    off_t                       off_s;
    logic [MOD_W-1:0]           off_ext;
    logic [NSTG*ACC_W-1:0]      acc_v;

    assign act = ord_mask(ord_i);

    for (genvar g = 0; g < NSTG; g++) begin : g_stg
        if (g == 0) begin : g_head
            assign add_w[g] = k_i;
        end else begin : g_tail
            assign add_w[g] = nxt_w[g-1];
        end
        mash111_stage #(.ACC_W(ACC_W)) u_stg (
            .act_i   (act[g]),
            .add_i   (add_w[g]),
            .state_i (st_q.acc[g]),
            .nxt_o   (nxt_w[g]),
            .carry_o (cy_w[g])
        );
    end

    mash111_comb u_comb (
        .act_i   (act),
        .cy_i    (cy_w),
        .c2_z1_i (st_q.c2_z1),
        .c3_z1_i (st_q.c3_z1),
        .c3_z2_i (st_q.c3_z2),
        .off_o   (off_s)
    );

    assign off_ext = {{(MOD_W-OFF_W){off_s[OFF_W-1]}}, off_s};
    assign acc_v   = st_q.acc;

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.acc   = seed_i;
            st_d.c2_z1 = 1'b0;
            st_d.c3_z1 = 1'b0;
            st_d.c3_z2 = 1'b0;
            st_d.modv  = '0;
        end else if (en_i) begin
            st_d.acc   = nxt_w;
            st_d.c2_z1 = act[1] & cy_w[1];
            st_d.c3_z1 = act[2] & cy_w[2];
            st_d.c3_z2 = act[2] & st_q.c3_z1;
            st_d.modv  = {1'b0, int_i} + off_ext;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign mod_o = st_q.modv;
endmodule

// File: rtl/mash111_chk.sv
`timescale 1ns/1ps
module mash111_chk #(
    parameter int ACC_W = 19,
    parameter int MOD_W = 9
) (
    input logic                    clk_i,
    input logic                    rst_i,
    input logic                    en_i,
    input logic [2:0]              act_i,
    input logic signed [3:0]       off_i,
    input logic [3*ACC_W-1:0]      acc_i,
    input logic [MOD_W-1:0]        mod_i
);
    // R3
    off_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |-> (off_i >= -4'sd3 && off_i <= 4'sd4));

    // R3
    ord1_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && act_i == 3'b001) |-> (off_i == 4'sd0 || off_i == 4'sd1));

    // R3
    ord2_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && act_i == 3'b011) |-> (off_i >= -4'sd1 && off_i <= 4'sd2));

    // R4
    stage2_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !act_i[1]) |=> (acc_i[2*ACC_W-1:ACC_W] == '0));

    // R4
    stage3_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !act_i[2]) |=> (acc_i[3*ACC_W-1:2*ACC_W] == '0));

    // R7
    freeze_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> ($stable(mod_i) && $stable(acc_i)));
endmodule

bind mash111_mod mash111_chk #(.ACC_W(ACC_W), .MOD_W(MOD_W)) u_chk (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .en_i  (en_i),
    .act_i (act),
    .off_i (off_s),
    .acc_i (acc_v),
    .mod_i (mod_o)
);

// File: tb/mash111_mod_test.sv
`timescale 1ns/1ps
module mash111_mod_test;
    localparam int AW   = 19;
    localparam int IW   = 8;
    localparam int MW   = IW + 1;
    localparam int FULL = 1 << AW;
    localparam int KQ   = 1 << (AW - 2);
    localparam int KF   = 132766;

    logic            clk = 1'b0;
    logic            rst_r = 1'b1;
    logic            en_r = 1'b0;
    logic [AW-1:0]   k_r = '0;
    logic [IW-1:0]   int_r = '0;
    logic [1:0]      ord_r = 2'd1;
    logic [3*AW-1:0] seed_r = '0;
    logic [MW-1:0]   mod_w;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    int m_a [3];
    int m_c2p, m_c3p, m_c3pp, m_exp, m_y;

    always #10 clk = ~clk;

    mash111_mod #(.ACC_W(AW), .INT_W(IW)) uut (
        .clk_i  (clk),
        .rst_i  (rst_r),
        .en_i   (en_r),
        .k_i    (k_r),
        .int_i  (int_r),
        .ord_i  (ord_r),
        .seed_i (seed_r),
        .mod_o  (mod_w)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d, expected %0d", req, act, exp);
        end
    endtask

    task automatic m_reset();
        for (int i = 0; i < 3; i++) m_a[i] = int'(seed_r[i*AW +: AW]);
        m_c2p = 0; m_c3p = 0; m_c3pp = 0; m_exp = 0; m_y = 0;
    endtask

    task automatic m_step();
        bit two, three;
        int s, c1, c2, c3, y;
        two   = (ord_r >= 2);
        three = (ord_r == 3);
        s = m_a[0] + int'(k_r);
        c1 = (s >= FULL) ? 1 : 0;
        m_a[0] = s % FULL;
        c2 = 0; c3 = 0;
        if (two) begin
            s = m_a[1] + m_a[0];
            c2 = (s >= FULL) ? 1 : 0;
            m_a[1] = s % FULL;
        end else m_a[1] = 0;
        if (three) begin
            s = m_a[2] + m_a[1];
            c3 = (s >= FULL) ? 1 : 0;
            m_a[2] = s % FULL;
        end else m_a[2] = 0;
        y = c1;
        if (two)   y += c2 - m_c2p;
        if (three) y += c3 - 2 * m_c3p + m_c3pp;
        m_c3pp = three ? m_c3p : 0;
        m_c3p  = three ? c3 : 0;
        m_c2p  = two ? c2 : 0;
        m_y    = y;
        m_exp  = ((int'(int_r) + y) % (1 << MW) + (1 << MW)) % (1 << MW);
    endtask

    // one clock: model follows the same edge, result sampled at the falling edge
    task automatic cyc();
        if (rst_r) m_reset();
        else if (en_r) m_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_r = 1'b1;
        cyc();
        cyc();
        rst_r = 1'b0;
    endtask

    task automatic run_model(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            cyc();
            chk(req, int'(mod_w), m_exp);
        end
    endtask

    task automatic t_reset_state();
        seed_r = '0; en_r = 1'b1;
        do_reset();
        chk("R6 reset clears modulus", int'(mod_w), 0);
    endtask

    task automatic t_quarter_pattern();
        int pat [4] = '{10, 10, 10, 11};
        ord_r = 2'd1; k_r = AW'(KQ); int_r = 8'd10; seed_r = '0; en_r = 1'b1;
        do_reset();
        for (int i = 0; i < 8; i++) begin
            cyc();
            chk("R9 R1 quarter pattern", int'(mod_w), pat[i % 4]);
        end
    endtask

    task automatic t_seed_shift();
        int pat [5] = '{11, 10, 10, 10, 11};
        ord_r = 2'd0; k_r = AW'(KQ); int_r = 8'd10;
        seed_r = '0; seed_r[AW-1:0] = AW'(3 * KQ); en_r = 1'b1;
        do_reset();
        for (int i = 0; i < 5; i++) begin
            cyc();
            chk("R6 R9 seed shifts first carry", int'(mod_w), pat[i]);
        end
    endtask

    task automatic t_order2_model();
        ord_r = 2'd2; k_r = AW'(KF); int_r = 8'd40; seed_r = '0; en_r = 1'b1;
        do_reset();
        run_model("R2 R3 order two sequence", 600);
    endtask

    task automatic t_order3_wrap();
        ord_r = 2'd3; k_r = AW'(KF); int_r = 8'd1;
        seed_r = '0; seed_r[AW-1:0] = AW'(1); en_r = 1'b1;
        do_reset();
        run_model("R5 R3 order three with modulus wrap", 600);
    endtask

    task automatic t_upper_idle();
        ord_r = 2'd1; k_r = AW'(KF); int_r = 8'd20;
        seed_r = {AW'(7000), AW'(5000), AW'(0)}; en_r = 1'b1;
        do_reset();
        for (int i = 0; i < 100; i++) begin
            cyc();
            chk("R4 upper stages ignored", int'(mod_w), m_exp);
            checks++;
            if (m_y != 0 && m_y != 1) begin
                errors++;
                $display("FAIL R4 model offset out of order-1 range: got %0d, expected 0 or 1", m_y);
            end
        end
    endtask

    task automatic t_mean();
        int sum = 0;
        int n = 4096;
        int expv;
        ord_r = 2'd3; k_r = AW'(KF); int_r = 8'd40; seed_r = '0; en_r = 1'b1;
        do_reset();
        for (int i = 0; i < n; i++) begin
            cyc();
            sum += int'(mod_w) - 40;
        end
        expv = int'((longint'(n) * KF) / FULL);
        checks++;
        if (sum < expv - 4 || sum > expv + 4) begin
            errors++;
            $display("FAIL R8 offset sum: got %0d, expected %0d +-4", sum, expv);
        end
    endtask

    task automatic t_freeze();
        int held;
        ord_r = 2'd3; k_r = AW'(KF); int_r = 8'd50; seed_r = '0; en_r = 1'b1;
        do_reset();
        run_model("R7 run before hold", 37);
        held = int'(mod_w);
        en_r = 1'b0;
        for (int i = 0; i < 6; i++) begin
            cyc();
            chk("R7 output held while disabled", int'(mod_w), held);
        end
        en_r = 1'b1;
        run_model("R7 state kept across hold", 60);
    endtask

    task automatic t_order_switch();
        ord_r = 2'd3; k_r = AW'(KF); int_r = 8'd60; seed_r = '0; en_r = 1'b1;
        do_reset();
        run_model("R4 switch order 3", 50);
        ord_r = 2'd1;
        run_model("R4 switch order 1", 50);
        ord_r = 2'd2;
        run_model("R4 switch order 2", 50);
        ord_r = 2'd3;
        run_model("R4 switch back order 3", 50);
    endtask

    task automatic t_reset_priority();
        ord_r = 2'd1; k_r = AW'(KQ); int_r = 8'd30; seed_r = '0; en_r = 1'b1;
        do_reset();
        run_model("R6 run before reset", 3);
        rst_r = 1'b1;
        cyc();
        chk("R6 reset beats enable", int'(mod_w), 0);
        rst_r = 1'b0;
        run_model("R6 restart from seeds", 8);
    endtask

    initial begin
        #4_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_quarter_pattern();
        t_seed_shift();
        t_order2_model();
        t_order3_wrap();
        t_upper_idle();
        t_mean();
        t_freeze();
        t_order_switch();
        t_reset_priority();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule